// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block keeps the working state of one DMA channel: a source address register, a destination address register, a transfer counter and a block counter. After it is enabled and a transfer request arrives, it runs one transfer. In dual-address operation a transfer is a read bus cycle at the source followed by a write bus cycle at the destination. In single-address operation a transfer is one bus cycle at the source address, and a control bit sets its direction. The bus address is loaded into a register on the clock edge before each bus cycle. The address register that supplied it moves on that same edge, so software reading the registers during a bus cycle sees values that have already been updated.

The counter has three uses, set by the transfer mode. In normal mode it counts down the remaining transfers. When it runs out, the channel pulses `done` and disables itself. In repeat mode the channel runs without end: each time the count expires, a dead cycle restores both addresses and the count to their programmed start values. In block mode the counter holds the block size. The block counter decrements on the last transfer of each block. A dead cycle follows every block, and the channel finishes after the dead cycle of the final block. A forced stop lets any bus cycle in progress finish, then parks the channel without signalling completion.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset all readable registers are zero, `bus_valid` is low and `done` is low.
- R2: In dual-address mode (control bit 1 = 1) a transfer is a read (`bus_write`=0) at the source address, then a write (`bus_write`=1) at the destination address. `bus_valid` and `bus_addr` stay unchanged until the cycle in which `bus_ready` is high.
- R3: In single-address mode (control bit 1 = 0) a transfer is one bus cycle at the source address. `bus_write` equals control bit 10.
- R4: Control bits 7:6 (source) and 9:8 (destination) choose how each address register moves after use: 0 = stays fixed, 1 = increments, 2 = decrements. The step is 1, 2 or 4 bytes when control bits 5:4 are 0, 1 or 2.
- R5: The address register moves on the edge that loads its old value onto `bus_addr`. During the source bus cycle, reading register select 0 returns the already-moved value.
- R6: In normal mode (control bits 3:2 = 0) the count (select 2) decrements once per transfer. After the last bus cycle of the transfer that brings it to zero, `done` is high for exactly one cycle and the enable bit (control bit 0) reads back 0.
- R7: In repeat mode (bits 3:2 = 1), a dead cycle with no bus activity follows the transfer that empties the count. That dead cycle restores both addresses and the count to their last written values, and the channel stays enabled with no `done`.
- R8: In block mode (bits 3:2 = 2), the count is the block size and is restored, together with both addresses, in a dead cycle after each block. The block counter (select 3) decrements only on the last transfer of a block. `done` pulses after the dead cycle of the block that brings it to zero.
- R9: Writing the control register (select 4) with bit 0 = 0 while enabled clears the enable. A bus cycle already in progress still completes, no further bus cycle is started, and `done` stays low.
- R10: While the channel is enabled, writes to select 0–3 are ignored. Writes to select 4 are ignored except for a forced stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Write select: 0 source, 1 destination, 2 count, 3 block count, 4 control |
| cfg_wdata | input | AW | Write data |
| rd_sel | input | 3 | Read select, same encoding as `cfg_sel` |
| rd_data | output | AW | Live value of the selected register |
| req | input | 1 | Transfer request, sampled while the channel is idle |
| bus_valid | output | 1 | A bus cycle is presented |
| bus_ready | input | 1 | The bus accepts the presented cycle on this edge |
| bus_addr | output | AW | Address of the presented bus cycle |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| done | output | 1 | One-cycle pulse when a normal or block sequence completes |

## Verification
The bench sweeps every combination of single and dual addressing, the three unit sizes and the three step settings of both address registers. For each combination it runs both a one-transfer count and a three-transfer count, and it computes every expected bus address arithmetically. A design that moved its address before presenting it would be off by one step on every bus cycle. A design whose readback lagged by one cycle would fail the check made during the source bus cycle. A design that issued `done` twice, or left the enable set after the count expired, is caught by the checks made after the sequence ends. The repeat and block runs require the addresses to fold back to their start values after every dead cycle and the block counter to reach zero exactly when the sequence ends. The forced-stop run clears the enable in the middle of a stalled read. That read must still complete, and no write may follow it.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUS1 = 2'd1, ST_BUS2 = 2'd2, ST_DEAD = 2'd3} seq_state_e;
  typedef enum logic [1:0] {XM_NORMAL = 2'd0, XM_REPEAT = 2'd1, XM_BLOCK = 2'd2, XM_RSVD = 2'd3} xfer_mode_e;
  typedef enum logic [1:0] {AS_FIXED = 2'd0, AS_INC = 2'd1, AS_DEC = 2'd2, AS_RSVD = 2'd3} addr_step_e;

  // bit 0 enable, 1 dual, 3:2 mode, 5:4 unit size, 7:6 src step, 9:8 dst step, 10 direction
  typedef struct packed {
    logic       dir;
    addr_step_e dst_step;
    addr_step_e src_step;
    logic [1:0] size;
    xfer_mode_e mode;
    logic       dual;
    logic       en;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);
  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_BLK  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;
endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  addr_step_e    step,
  input  logic [1:0]    size,
  input  logic          advance,
  input  logic          restore,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] cur_q, start_q, delta;

  assign delta = AW'(1) << size;
  assign cur   = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      start_q <= '0;
    end else if (load) begin
      cur_q   <= load_val;
      start_q <= load_val;
    end else if (restore) begin
      cur_q <= start_q;
    end else if (advance) begin
      unique case (step)
        AS_INC:  cur_q <= cur_q + delta;
        AS_DEC:  cur_q <= cur_q - delta;
        default: cur_q <= cur_q;
      endcase
    end
  end

  p_fixed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load && !restore && step == AS_FIXED |=> $stable(cur));

  p_restore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore && !load |=> cur == $past(start_q));
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_cnt,
  input  logic          load_blk,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic          blk_mode,
  input  logic          restore,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] blk,
  output logic          cnt_last,
  output logic          blk_last
);
  logic [CW-1:0] cnt_q, init_q, blk_q;

  assign cnt      = cnt_q;
  assign blk      = blk_q;
  assign cnt_last = (cnt_q == CW'(1));
  assign blk_last = (blk_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      init_q <= '0;
    end else if (load_cnt) begin
      cnt_q  <= load_val;
      init_q <= load_val;
    end else if (restore) begin
      cnt_q <= init_q;
    end else if (dec) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          blk_q <= '0;
    else if (load_blk)                   blk_q <= load_val;
    else if (dec && blk_mode && cnt_last) blk_q <= blk_q - CW'(1);
  end

  p_blk_only_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_blk && !(dec && blk_mode && cnt_last) |=> $stable(blk));

  p_count_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !load_cnt && !restore |=> cnt == $past(cnt) - CW'(1));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [2:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          req,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          done
);
  localparam int NADDR = 2;

  seq_state_e    state;
  chan_ctrl_t    ctrl;
  logic [AW-1:0] iaddr;
  logic          last_q, blk_end_q, done_q;

  logic [AW-1:0] a_cur  [NADDR];
  logic          a_load [NADDR];
  logic          a_adv  [NADDR];
  addr_step_e    a_step [NADDR];

  logic [CW-1:0] cnt, blk;
  logic          cnt_last, blk_last;
  logic          wr_ok, ctrl_wr, go, fin, restore;

  assign wr_ok   = cfg_we && !ctrl.en;
  assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
  assign go      = (state == ST_IDLE) && ctrl.en && req;
  assign fin     = bus_ready && ctrl.en &&
                   (((state == ST_BUS1) && !ctrl.dual) || (state == ST_BUS2));
  assign restore = (state == ST_DEAD);

  assign a_load[0] = wr_ok && (cfg_sel == SEL_SRC);
  assign a_load[1] = wr_ok && (cfg_sel == SEL_DST);
  assign a_adv[0]  = go;
  assign a_adv[1]  = (state == ST_BUS1) && bus_ready && ctrl.en && ctrl.dual;
  assign a_step[0] = ctrl.src_step;
  assign a_step[1] = ctrl.dst_step;

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    dma_addr_reg #(.AW(AW)) u_areg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (a_load[g]),
      .load_val (cfg_wdata),
      .step     (a_step[g]),
      .size     (ctrl.size),
      .advance  (a_adv[g]),
      .restore  (restore),
      .cur      (a_cur[g])
    );
  end

  dma_xfer_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_cnt (wr_ok && (cfg_sel == SEL_CNT)),
    .load_blk (wr_ok && (cfg_sel == SEL_BLK)),
    .load_val (cfg_wdata[CW-1:0]),
    .dec      (go),
    .blk_mode (ctrl.mode == XM_BLOCK),
    .restore  (restore),
    .cnt      (cnt),
    .blk      (blk),
    .cnt_last (cnt_last),
    .blk_last (blk_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ctrl      <= '0;
      iaddr     <= '0;
      last_q    <= 1'b0;
      blk_end_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ctrl_wr) begin
        if (!ctrl.en)          ctrl    <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        else if (!cfg_wdata[0]) ctrl.en <= 1'b0;
      end
      unique case (state)
        ST_IDLE: if (go) begin
          state     <= ST_BUS1;
          iaddr     <= a_cur[0];
          last_q    <= cnt_last;
          blk_end_q <= blk_last;
        end
        ST_BUS1: begin
          if (bus_ready && !ctrl.en) state <= ST_IDLE;
          else if (bus_ready && ctrl.dual) begin
            state <= ST_BUS2;
            iaddr <= a_cur[1];
          end
        end
        ST_BUS2: if (bus_ready && !ctrl.en) state <= ST_IDLE;
        ST_DEAD: begin
          state <= ST_IDLE;
          if (ctrl.en && (ctrl.mode == XM_BLOCK) && blk_end_q) begin
            done_q  <= 1'b1;
            ctrl.en <= 1'b0;
          end
        end
      endcase
      if (fin) begin
        if (!last_q) state <= ST_IDLE;
        else if (ctrl.mode == XM_NORMAL) begin
          state   <= ST_IDLE;
          done_q  <= 1'b1;
          ctrl.en <= 1'b0;
        end else state <= ST_DEAD;
      end
    end
  end

  assign bus_valid = (state == ST_BUS1) || (state == ST_BUS2);
  assign bus_addr  = iaddr;
  assign bus_write = (state == ST_BUS2) || ((state == ST_BUS1) && !ctrl.dual && ctrl.dir);
  assign done      = done_q;

  always_comb begin
    unique case (rd_sel)
      SEL_SRC:  rd_data = a_cur[0];
      SEL_DST:  rd_data = a_cur[1];
      SEL_CNT:  rd_data = AW'(cnt);
      SEL_BLK:  rd_data = AW'(blk);
      SEL_CTRL: rd_data = AW'(ctrl);
      default:  rd_data = '0;
    endcase
  end

  p_hold_until_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctrl.en);

  p_dead_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore |-> !bus_valid);

  p_stop_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en && !bus_valid |=> !bus_valid);
endmodule

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        req = 1'b0;
  logic        bus_valid;
  logic        bus_ready = 1'b1;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic        g_dual, g_dir;
  logic [31:0] src0, dst0, dsv, ddv, g_ctrl;

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .req(req), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_write(bus_write), .done(done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1 val = rd_data;
    rd_sel = 3'd0;
  endtask

  function automatic logic [31:0] step_of(input int st, input int sz);
    logic [31:0] u;
    u = 32'd1 << sz;
    return (st == 1) ? u : (st == 2) ? -u : 32'd0;
  endfunction

  task automatic setup(input int dual, input int mode, input int sz, input int ss, input int ds,
                       input int dir, input int cnt, input int blk, input logic [31:0] s0,
                       input logic [31:0] d0);
    req = 1'b0; bus_ready = 1'b1;
    g_dual = dual[0]; g_dir = dir[0]; src0 = s0; dst0 = d0;
    dsv = step_of(ss, sz); ddv = step_of(ds, sz);
    g_ctrl = (32'(dir) << 10) | (32'(ds) << 8) | (32'(ss) << 6) | (32'(sz) << 4) |
             (32'(mode) << 2) | (32'(dual) << 1);
    wr(3'd4, g_ctrl);
    wr(3'd0, s0);
    wr(3'd1, d0);
    wr(3'd2, 32'(cnt));
    wr(3'd3, 32'(blk));
    wr(3'd4, g_ctrl | 32'd1);
  endtask

  // Runs 'total' transfers; addresses fold back every 'per' transfers.
  task automatic run_xfers(input int total, input int per, input bit waits,
                           output int dones, output int tail_valid);
    int i, ph, guard, cyc, j;
    logic [31:0] ea, act;
    i = 0; ph = 0; guard = 0; cyc = 0; dones = 0; tail_valid = 0;
    rd_sel = 3'd0;
    req = 1'b1;
    while (i < total && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (done) dones++;
      bus_ready = waits ? cyc[0] : 1'b1;
      cyc++;
      if (bus_valid && bus_ready) begin
        j = i % per;
        if (g_dual && ph == 1) begin
          ea = dst0 + 32'(j) * ddv;
          chk("R2 dst address", bus_addr, ea);
          chk("R2 write phase", {31'd0, bus_write}, 32'd1);
        end else begin
          ea = src0 + 32'(j) * dsv;
          chk("R4 src address", bus_addr, ea);
          if (g_dual) begin
            chk("R2 read phase", {31'd0, bus_write}, 32'd0);
            #1 act = rd_data;
            chk("R5 live src readback", act, ea + dsv);
          end else begin
            chk("R3 direction", {31'd0, bus_write}, {31'd0, g_dir});
          end
        end
        if (g_dual && ph == 0) ph = 1;
        else begin ph = 0; i++; end
      end
    end
    if (guard >= 3000) chk("R2 transfers stalled", 32'(i), 32'(total));
    req = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      bus_ready = 1'b1;
      if (done) dones++;
      if (bus_valid) tail_valid++;
    end
  endtask

  initial begin
    logic [31:0] v;
    int dn, tv;
    #9;
    @(negedge clk);
    chk("R1 bus_valid after reset", {31'd0, bus_valid}, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      chk("R1 register after reset", v, 32'd0);
    end
    rst_n = 1'b1;

    // Sweep of normal mode over addressing, size and both step settings.
    for (int du = 0; du < 2; du++)
      for (int sz = 0; sz < 3; sz++)
        for (int ss = 0; ss < 3; ss++)
          for (int ds = 0; ds < 3; ds++)
            for (int n = 1; n <= 3; n += 2) begin
              setup(du, 0, sz, ss, ds, ss & 1, n, 0, 32'h1000 + 32'(sz * 16), 32'h8000);
              run_xfers(n, n, n == 3, dn, tv);
              chk("R6 one done pulse", 32'(dn), 32'd1);
              chk("R6 no bus after done", 32'(tv), 32'd0);
              rd(3'd4, v);
              chk("R6 enable cleared", {31'd0, v[0]}, 32'd0);
              rd(3'd2, v);
              chk("R6 count at zero", v, 32'd0);
              rd(3'd0, v);
              chk("R4 final src", v, src0 + 32'(n) * dsv);
              rd(3'd1, v);
              chk("R4 final dst", v, du ? dst0 + 32'(n) * ddv : dst0);
            end

    // Repeat mode, single address; writes while enabled are ignored.
    setup(0, 1, 2, 1, 0, 0, 3, 0, 32'h2000, 32'h9000);
    wr(3'd0, 32'hDEAD0000);
    wr(3'd2, 32'd9);
    rd(3'd0, v);
    chk("R10 src write ignored", v, 32'h2000);
    rd(3'd2, v);
    chk("R10 count write ignored", v, 32'd3);
    run_xfers(7, 3, 1'b1, dn, tv);
    chk("R7 no done in repeat", 32'(dn), 32'd0);
    rd(3'd2, v);
    chk("R7 count after reload", v, 32'd2);
    rd(3'd0, v);
    chk("R7 src after restore", v, 32'h2004);
    rd(3'd4, v);
    chk("R7 still enabled", {31'd0, v[0]}, 32'd1);
    wr(3'd4, g_ctrl);
    rd(3'd4, v);
    chk("R9 stop clears enable", {31'd0, v[0]}, 32'd0);

    // Block mode: block size 2, three blocks.
    setup(1, 2, 1, 1, 2, 0, 2, 3, 32'h3000, 32'hA000);
    run_xfers(6, 2, 1'b0, dn, tv);
    chk("R8 one done pulse", 32'(dn), 32'd1);
    chk("R8 no bus after done", 32'(tv), 32'd0);
    rd(3'd3, v);
    chk("R8 block counter zero", v, 32'd0);
    rd(3'd2, v);
    chk("R8 block size restored", v, 32'd2);
    rd(3'd0, v);
    chk("R8 src restored", v, 32'h3000);
    rd(3'd1, v);
    chk("R8 dst restored", v, 32'hA000);

    // Forced stop during a stalled read.
    setup(1, 0, 0, 1, 1, 0, 4, 0, 32'h4000, 32'hB000);
    bus_ready = 1'b0;
    req = 1'b1;
    for (int k = 0; k < 20 && !bus_valid; k++) @(negedge clk);
    chk("R9 read started", {31'd0, bus_valid}, 32'd1);
    cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = g_ctrl;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 read held after stop", {31'd0, bus_valid}, 32'd1);
    bus_ready = 1'b1;
    dn = 0; tv = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) dn++;
      if (bus_valid) tv++;
    end
    req = 1'b0;
    chk("R9 no write after stop", 32'(tv), 32'd0);
    chk("R9 no done after stop", 32'(dn), 32'd0);
    rd(3'd2, v);
    chk("R9 one transfer counted", v, 32'd3);
    rd(3'd1, v);
    chk("R9 dst untouched", v, 32'hB000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule